// File: doc/BRIEF.md
# Compressed Segment Shift Engine

This block is the per-hop stage that processes the outer IPv6 destination address of a source-routed packet whose path is written as a list of 16-bit compressed segments. These segments sit behind a fixed 32-bit locator prefix. Each node is configured with one locator value and one 16-bit node value. No per-flow state is kept: every packet that names the node is handled by the same single identifier.

For each packet accepted on the input valid/ready interface, the block compares the locator and the active segment (the 16 bits right after the locator) with the configured identifier. The outcome has four cases:

- **Match, more segments follow:** the list moves up by one slot, the hop limit is decremented, and the packet is forwarded.
- **Match, last segment:** the block tells the downstream logic to strip the outer header.
- **Match, hop limit exhausted:** the packet is marked for drop.
- **No match:** the packet passes unchanged for an ordinary route lookup.

In every case the segment now at the active position is presented as the key for the next table lookup.

Top module: `seg_shift_engine`

## Requirements
- R1: The upper 32 bits of every output address equal the upper 32 bits of the accepted input address.
- R2: A packet matches only when input bits 127:96 equal the configured locator and bits 95:80 equal the configured node value. A packet that does not match leaves with action code 0 (pass), with address and hop limit unchanged, and key = input bits 95:80.
- R3: A matching packet with any nonzero bit in 79:0 and hop limit of 2 or more leaves with action code 1 (forward). Its address is {bits 127:96, bits 79:0, 16'h0000}, its hop limit is the input minus one, and its key is input bits 79:64.
- R4: A matching packet whose bits 79:0 are all zero leaves with action code 2 (decapsulate), with address and hop limit unchanged and key 0, whatever the hop limit.
- R5: A matching packet with a nonzero bit in 79:0 and hop limit 0 or 1 leaves with action code 3 (drop), with address and hop limit unchanged and key 0.
- R6: An address holding six segments, passed through six nodes in turn, is forwarded five times and decapsulated at the sixth node.
- R7: The result appears with out_valid high in the cycle after the input is accepted. It stays stable while out_ready is low, and in_ready equals (not out_valid) or out_ready.
- R8: A configuration write (cfg_we) takes effect only when out_valid and in_valid are both low. Otherwise it is ignored, and later packets are judged against the previous identifier.
- R9: After reset, out_valid is low, in_ready is high, and the identifier is locator 32'h5f000000 with node 16'h0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input packet present |
| in_ready | output | 1 | Block can take a packet |
| in_addr | input | 128 | Outer destination address |
| in_hlim | input | 8 | Outer hop limit |
| cfg_we | input | 1 | Load identifier (honoured only while idle) |
| cfg_loc | input | 32 | Locator value to load |
| cfg_node | input | 16 | Node value to load |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_act | output | 2 | 0 pass, 1 forward, 2 decapsulate, 3 drop |
| out_addr | output | 128 | Rewritten or original address |
| out_hlim | output | 8 | Outgoing hop limit |
| out_key | output | 16 | Key for the next lookup |

## Verification
The bench builds the block with its default widths: a 128-bit address, a 32-bit locator and 16-bit segments. This gives exactly six segment slots, so the full-length chain of R6 can be walked, including the final slot where the zero fill and the decapsulate decision meet. The defaults also keep the reset identifier at locator 5f000000 and node 0100, so the reset configuration can be confirmed just by sending a packet that names it. Hop limits 0, 1 and 2 reach the drop/forward boundary. A held output with out_ready low exercises backpressure.

// File: rtl/seg_pkg.sv
package seg_pkg;
   typedef enum logic [1:0] {
      ACT_PASS  = 2'd0,
      ACT_FWD   = 2'd1,
      ACT_DECAP = 2'd2,
      ACT_DROP  = 2'd3
   } seg_act_e;
endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs #(
   parameter int              LOC_W    = 32,
   parameter int              SEG_W    = 16,
   parameter logic [LOC_W-1:0] RST_LOC  = '0,
   parameter logic [SEG_W-1:0] RST_NODE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             idle,
   input  logic [LOC_W-1:0] wr_loc,
   input  logic [SEG_W-1:0] wr_node,
   output logic [LOC_W-1:0] loc,
   output logic [SEG_W-1:0] node
);
   // identifier changes only between packets so no result mixes two configs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc  <= RST_LOC;
         node <= RST_NODE;
      end else if (wr_en && idle) begin
         loc  <= wr_loc;
         node <= wr_node;
      end
   end
endmodule

// File: rtl/seg_shifter.sv
module seg_shifter #(
   parameter int ADDR_W = 128,
   parameter int LOC_W  = 32,
   parameter int SEG_W  = 16
) (
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic              more,
   output logic [SEG_W-1:0]  next_key
);
   localparam int TAIL_W = ADDR_W - LOC_W;
   localparam int NSEG   = TAIL_W / SEG_W;

   logic [NSEG-1:0]   slot_nz;
   logic [TAIL_W-1:0] tail_new;

   for (genvar i = 0; i < NSEG; i++) begin : g_slot
      localparam int HI = TAIL_W - 1 - i * SEG_W;
      if (i == NSEG - 1) begin : g_last
         assign tail_new[HI -: SEG_W] = '0;
      end else begin : g_move
         assign tail_new[HI -: SEG_W] = addr_in[HI - SEG_W -: SEG_W];
      end
      if (i == 0) begin : g_act
         assign slot_nz[i] = 1'b0;
      end else begin : g_rest
         assign slot_nz[i] = |addr_in[HI -: SEG_W];
      end
   end

   assign addr_out = {addr_in[ADDR_W-1 -: LOC_W], tail_new};
   assign more     = |slot_nz;
   assign next_key = tail_new[TAIL_W-1 -: SEG_W];
endmodule

// File: rtl/seg_decide.sv
module seg_decide
   import seg_pkg::*;
#(
   parameter int ADDR_W = 128,
   parameter int LOC_W  = 32,
   parameter int SEG_W  = 16,
   parameter int HL_W   = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [HL_W-1:0]   hlim,
   input  logic [LOC_W-1:0]  loc,
   input  logic [SEG_W-1:0]  node,
   input  logic [ADDR_W-1:0] shifted,
   input  logic              more,
   input  logic [SEG_W-1:0]  next_key,
   output seg_act_e          act,
   output logic [ADDR_W-1:0] addr_o,
   output logic [HL_W-1:0]   hlim_o,
   output logic [SEG_W-1:0]  key_o
);
   localparam int ACT_HI = ADDR_W - LOC_W - 1;

   logic hit;
   assign hit = (addr[ADDR_W-1 -: LOC_W] == loc) && (addr[ACT_HI -: SEG_W] == node);

   always_comb begin
      act    = ACT_PASS;
      addr_o = addr;
      hlim_o = hlim;
      key_o  = addr[ACT_HI -: SEG_W];
      if (hit) begin
         key_o = '0;
         if (!more) begin
            act = ACT_DECAP;
         end else if (hlim < HL_W'(2)) begin
            act = ACT_DROP;
         end else begin
            act    = ACT_FWD;
            addr_o = shifted;
            hlim_o = hlim - HL_W'(1);
            key_o  = next_key;
         end
      end
   end
endmodule

// File: rtl/seg_shift_engine.sv
module seg_shift_engine
   import seg_pkg::*;
#(
   parameter int ADDR_W = 128,
   parameter int LOC_W  = 32,
   parameter int SEG_W  = 16,
   parameter int HL_W   = 8,
   parameter logic [LOC_W-1:0] RST_LOC  = 32'h5f00_0000,
   parameter logic [SEG_W-1:0] RST_NODE = 16'h0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [HL_W-1:0]   in_hlim,
   input  logic              cfg_we,
   input  logic [LOC_W-1:0]  cfg_loc,
   input  logic [SEG_W-1:0]  cfg_node,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_act,
   output logic [ADDR_W-1:0] out_addr,
   output logic [HL_W-1:0]   out_hlim,
   output logic [SEG_W-1:0]  out_key
);
   localparam int TAIL_W = ADDR_W - LOC_W;
   localparam int NSEG   = TAIL_W / SEG_W;

   if (LOC_W <= 0 || SEG_W <= 0 || LOC_W >= ADDR_W) begin : g_bad_w
      $error("seg_shift_engine: locator and segment widths must fit the address");
   end
   if (TAIL_W % SEG_W != 0) begin : g_bad_div
      $error("seg_shift_engine: address tail must hold whole segments");
   end
   if (NSEG < 2) begin : g_bad_n
      $error("seg_shift_engine: at least two segment slots required");
   end
   if (HL_W < 2) begin : g_bad_hl
      $error("seg_shift_engine: hop limit needs two or more bits");
   end

   logic [LOC_W-1:0]  loc_q;
   logic [SEG_W-1:0]  node_q;
   logic [ADDR_W-1:0] sh_addr;
   logic              sh_more;
   logic [SEG_W-1:0]  sh_key;
   seg_act_e          d_act;
   logic [ADDR_W-1:0] d_addr;
   logic [HL_W-1:0]   d_hlim;
   logic [SEG_W-1:0]  d_key;
   logic              take;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   seg_cfg_regs #(
      .LOC_W(LOC_W), .SEG_W(SEG_W), .RST_LOC(RST_LOC), .RST_NODE(RST_NODE)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we),
      .idle(!out_valid && !in_valid),
      .wr_loc(cfg_loc), .wr_node(cfg_node),
      .loc(loc_q), .node(node_q)
   );

   seg_shifter #(.ADDR_W(ADDR_W), .LOC_W(LOC_W), .SEG_W(SEG_W)) u_shift (
      .addr_in(in_addr), .addr_out(sh_addr), .more(sh_more), .next_key(sh_key)
   );

   seg_decide #(.ADDR_W(ADDR_W), .LOC_W(LOC_W), .SEG_W(SEG_W), .HL_W(HL_W)) u_dec (
      .addr(in_addr), .hlim(in_hlim), .loc(loc_q), .node(node_q),
      .shifted(sh_addr), .more(sh_more), .next_key(sh_key),
      .act(d_act), .addr_o(d_addr), .hlim_o(d_hlim), .key_o(d_key)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_act   <= '0;
         out_addr  <= '0;
         out_hlim  <= '0;
         out_key   <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (take) begin
            out_act  <= d_act;
            out_addr <= d_addr;
            out_hlim <= d_hlim;
            out_key  <= d_key;
         end
      end
   end
endmodule

// File: rtl/seg_shift_chk.sv
module seg_shift_chk #(
   parameter int ADDR_W = 128,
   parameter int LOC_W  = 32,
   parameter int SEG_W  = 16,
   parameter int HL_W   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [ADDR_W-1:0] in_addr,
   input logic [HL_W-1:0]   in_hlim,
   input logic              out_valid,
   input logic              out_ready,
   input logic [1:0]        out_act,
   input logic [ADDR_W-1:0] out_addr,
   input logic [HL_W-1:0]   out_hlim,
   input logic [SEG_W-1:0]  out_key
);
   logic [ADDR_W-1:0] cap_addr;
   logic [HL_W-1:0]   cap_hlim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr <= '0;
         cap_hlim <= '0;
      end else if (in_valid && in_ready) begin
         cap_addr <= in_addr;
         cap_hlim <= in_hlim;
      end
   end

   a_r1_loc_kept: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_addr[ADDR_W-1 -: LOC_W] == cap_addr[ADDR_W-1 -: LOC_W]);

   a_r2_pass_same: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_act == 2'd0) |-> (out_addr == cap_addr && out_hlim == cap_hlim));

   a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_act == 2'd1) |->
         (out_addr[SEG_W-1:0] == '0 && out_hlim == cap_hlim - HL_W'(1) && cap_hlim > HL_W'(1)));

   a_r4_decap_key: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_act == 2'd2) |-> (out_addr == cap_addr && out_key == '0));

   a_r5_drop_low_hl: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_act == 2'd3) |-> (cap_hlim < HL_W'(2) && out_key == '0));

   a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_addr) && $stable(out_act) && $stable(out_key)));
endmodule

bind seg_shift_engine seg_shift_chk #(
   .ADDR_W(ADDR_W), .LOC_W(LOC_W), .SEG_W(SEG_W), .HL_W(HL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_addr(in_addr), .in_hlim(in_hlim), .out_valid(out_valid),
   .out_ready(out_ready), .out_act(out_act), .out_addr(out_addr),
   .out_hlim(out_hlim), .out_key(out_key)
);

// File: tb/sim_seg_shift_engine.sv
`timescale 1ns/1ps
module sim_seg_shift_engine;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_addr = '0;
   logic [7:0]   in_hlim = '0;
   logic         cfg_we = 1'b0;
   logic [31:0]  cfg_loc = '0;
   logic [15:0]  cfg_node = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [1:0]   out_act;
   logic [127:0] out_addr;
   logic [7:0]   out_hlim;
   logic [15:0]  out_key;

   always #2.5 clk = ~clk;

   seg_shift_engine u0 (.*);

   typedef struct {
      logic [1:0]   act;
      logic [127:0] addr;
      logic [7:0]   hl;
      logic [15:0]  key;
      string        req;
   } exp_t;

   exp_t        sb[$];
   int          total = 0;
   int          bad = 0;
   logic [31:0] m_loc = 32'h5f00_0000;
   logic [15:0] m_node = 16'h0100;
   bit          done = 1'b0;

   function automatic exp_t model(logic [127:0] a, logic [7:0] h, string r);
      exp_t e;
      e.req = r; e.addr = a; e.hl = h;
      if (!(a[127:96] == m_loc && a[95:80] == m_node)) begin
         e.act = 2'd0; e.key = a[95:80];
      end else if (a[79:0] == '0) begin
         e.act = 2'd2; e.key = '0;
      end else if (h < 8'd2) begin
         e.act = 2'd3; e.key = '0;
      end else begin
         e.act = 2'd1; e.addr = {a[127:96], a[79:0], 16'h0};
         e.hl = h - 8'd1; e.key = a[79:64];
      end
      return e;
   endfunction

   task automatic chk(bit ok, string r, string what, logic [127:0] act_v, logic [127:0] exp_v);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", r, what, act_v, exp_v);
      end
   endtask

   // monitor: compare each consumed result against the scoreboard head
   always @(negedge clk) begin
      #1;
      if (rst_n && out_valid && out_ready) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R7", "unexpected output", 128'(out_act), 128'(0));
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(out_act == e.act, e.req, "act", 128'(out_act), 128'(e.act));
            chk(out_addr == e.addr, e.req, "addr", out_addr, e.addr);
            chk(out_hlim == e.hl, e.req, "hlim", 128'(out_hlim), 128'(e.hl));
            chk(out_key == e.key, e.req, "key", 128'(out_key), 128'(e.key));
         end
      end
   end

   task automatic send(logic [127:0] a, logic [7:0] h, string r);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_addr = a; in_hlim = h;
      sb.push_back(model(a, h, r));
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R7", "valid after accept", 128'(out_valid), 128'(1));
   endtask

   task automatic drain();
      while (sb.size() != 0 || out_valid) @(negedge clk);
   endtask

   task automatic cfg(logic [31:0] l, logic [15:0] n);
      drain();
      @(negedge clk);
      cfg_we = 1'b1; cfg_loc = l; cfg_node = n;
      @(negedge clk);
      cfg_we = 1'b0;
      m_loc = l; m_node = n;
   endtask

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [127:0] a;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(out_valid == 1'b0, "R9", "out_valid in reset", 128'(out_valid), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R9", "out_valid after reset", 128'(out_valid), 128'(0));
      chk(in_ready == 1'b1, "R9", "in_ready after reset", 128'(in_ready), 128'(1));
      // R9 default identifier, R3 forward with shift
      send(128'h5f00_0000_0100_0500_0300_0000_0000_0000, 8'd64, "R9_R3");
      // R2 no match: other node, other locator
      send(128'h5f00_0000_0700_0500_0300_0000_0000_0000, 8'd9, "R2");
      send(128'h5f01_0000_0100_0500_0000_0000_0000_0000, 8'd9, "R2");
      // R4 last segment, even with hop limit 0
      send(128'h5f00_0000_0100_0000_0000_0000_0000_0000, 8'd30, "R4");
      send(128'h5f00_0000_0100_0000_0000_0000_0000_0000, 8'd0, "R4");
      // R5 hop limit boundary 1/0 drop, 2 forward
      send(128'h5f00_0000_0100_0000_0000_0000_0000_0001, 8'd1, "R5");
      send(128'h5f00_0000_0100_0600_0000_0000_0000_0000, 8'd0, "R5");
      send(128'h5f00_0000_0100_0600_0000_0000_0000_0000, 8'd2, "R5_R3");
      // R1 other locator with matching config
      cfg(32'h2001_0db8, 16'h00aa);
      send(128'h2001_0db8_00aa_00bb_00cc_00dd_00ee_00ff, 8'd255, "R1_R3");
      // R7 backpressure hold
      drain();
      @(negedge clk);
      out_ready = 1'b0;
      send(128'h2001_0db8_00aa_1111_0000_0000_0000_0000, 8'd5, "R7");
      @(negedge clk);
      in_valid = 1'b1;
      in_addr  = 128'h2001_0db8_00aa_2222_0000_0000_0000_0000;
      in_hlim  = 8'd6;
      #1;
      chk(in_ready == 1'b0, "R7", "in_ready while held", 128'(in_ready), 128'(0));
      chk(out_addr == 128'h2001_0db8_1111_0000_0000_0000_0000_0000, "R7",
          "held addr", out_addr, 128'h2001_0db8_1111_0000_0000_0000_0000_0000);
      sb.push_back(model(in_addr, in_hlim, "R7"));
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      drain();
      // R8 write while a packet is presented is ignored
      @(negedge clk);
      in_valid = 1'b1; cfg_we = 1'b1;
      cfg_loc = 32'h5f00_0000; cfg_node = 16'h0100;
      in_addr = 128'h2001_0db8_00aa_0001_0000_0000_0000_0000; in_hlim = 8'd7;
      sb.push_back(model(in_addr, in_hlim, "R8"));
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; cfg_we = 1'b0;
      send(128'h2001_0db8_00aa_0002_0000_0000_0000_0000, 8'd7, "R8");
      send(128'h5f00_0000_0100_0200_0000_0000_0000_0000, 8'd7, "R8");
      // R6 six-segment chain through six nodes
      a = 128'h5f00_0000_0100_0200_0300_0400_0500_0600;
      for (int k = 1; k <= 6; k++) begin
         exp_t e;
         cfg(32'h5f00_0000, 16'(k * 256));
         e = model(a, 8'd20, "R6");
         chk(e.act == ((k == 6) ? 2'd2 : 2'd1), "R6", "chain step kind",
             128'(e.act), 128'((k == 6) ? 2 : 1));
         send(a, 8'd20, "R6");
         a = e.addr;
      end
      drain();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule